// File: doc/BRIEF.md
# Run-Mode Clock Source Sequencer

This block decides which of three oscillator sources clocks a small microcontroller and whether the core and peripheral clocks run at all. The sources are a primary oscillator, a low-power secondary oscillator and an internal oscillator block. The internal block has a low-frequency fallback and a faster, programmable output. The core supplies a two-bit source-select field, an idle-enable bit and a one-cycle sleep request. The oscillators return ready or stable indications. The block answers with a one-hot source select, enables for each oscillator, gated enables for the core and peripheral clocks, and status flags.

Source changes are handshaked against readiness. A move onto the secondary oscillator waits until that oscillator is both enabled and ready. A move back from the secondary to the primary keeps running on the secondary until the primary reports ready. A sleep request stops the core clock. The idle-enable bit, sampled when the request arrives, decides whether the peripheral clock stops too. A single wake pulse restarts the clocks and resumes the mode given by the select field.

All outputs come from registers. Every output changes on the clock edge that samples the inputs causing the change, so no output glitches within a cycle.

Top module: `clkseq_top`

## Requirements
- R1: After reset, srcSel is 3'b001 (primary), priOscEn, coreClkEn and periClkEn are 1, secRunFlag and intFastStable are 0, and priStableFlag becomes 1 one edge after reset is released with priReady high.
- R2: srcSel (bit 0 primary, bit 1 secondary, bit 2 internal) always has exactly one bit set.
- R3: selField = 2'b01 selects the secondary source. Once it is active, srcSel is 3'b010, priOscEn is 0, secRunFlag is 1 and priStableFlag is 0.
- R4: The move to the secondary source happens on the first edge where selField = 2'b01, secEnable and secReady are all high. Until then, the current source stays selected.
- R5: When selField = 2'b00 is selected while the secondary source is active, srcSel stays 3'b010 with priOscEn = 1 until priReady is sampled high. On that edge srcSel becomes 3'b001, secRunFlag clears, priStableFlag sets and secOscEn stays 1.
- R6: selField[1] = 1 selects the internal source whatever selField[0] is. srcSel is then 3'b100, and priOscEn and priStableFlag are 0.
- R7: With intFreq = 0 and intSrcSel = 0, intOscEn and intFastStable are 0, even with intStable high. In internal mode lowFreqActive is then 1.
- R8: When intFreq goes from zero to non-zero, intOscEn sets on the next edge. intFastStable sets only on an edge after which intOscEn was already 1 and intStable is high. srcSel and coreClkEn do not change meanwhile.
- R9: If the fast internal output is already enabled and stable, entering internal mode leaves intFastStable at 1.
- R10: A sleepReq sampled with idleEn = 0 clears coreClkEn and periClkEn on that edge. With idleEn = 1 it clears coreClkEn only and periClkEn stays 1.
- R11: A wakePulse in sleep or idle sets coreClkEn and periClkEn on that edge. The source is chosen from the current selField on the same edge, subject to R4.
- R12: While in sleep or idle, changes on selField have no effect on srcSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selField | input | 2 | Source select: 00 primary, 01 secondary, 1x internal |
| idleEn | input | 1 | 1: a sleep request enters idle; 0: full sleep |
| sleepReq | input | 1 | One-cycle sleep request from the core |
| wakePulse | input | 1 | One-cycle wake-up event |
| priReady | input | 1 | Primary oscillator ready |
| secEnable | input | 1 | Software enable for the secondary oscillator |
| secReady | input | 1 | Secondary oscillator ready |
| intFreq | input | FREQ_W | Internal fast-output frequency code; 0 disables the fast output |
| intSrcSel | input | 1 | Forces the internal fast output on |
| intStable | input | 1 | Internal fast output stable |
| srcSel | output | 3 | One-hot active clock source |
| priOscEn | output | 1 | Primary oscillator enable |
| secOscEn | output | 1 | Secondary oscillator enable |
| intOscEn | output | 1 | Internal fast-output enable |
| lowFreqActive | output | 1 | The internal low-frequency fallback drives the clocks |
| coreClkEn | output | 1 | Core clock gate enable |
| periClkEn | output | 1 | Peripheral clock gate enable |
| secRunFlag | output | 1 | Clocks are running from the secondary oscillator |
| priStableFlag | output | 1 | Clocks are running from a ready primary oscillator |
| intFastStable | output | 1 | Internal fast output is enabled and stable |

## Verification
The hardest state to reach is the hand-back window. In it the select field already asks for the primary source while the clocks still come from the secondary oscillator. The stimulus first moves onto the secondary source, with its enable and ready gates released one at a time. It then drops priReady before selecting the primary, and holds it low for several cycles before raising it. A second hard case is a change of select while asleep. The stimulus changes selField between a sleep and a wake pulse, and then checks that the source follows the new field only on the wake edge.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 3;
  localparam int SRC_PRI = 0;
  localparam int SRC_SEC = 1;
  localparam int SRC_INT = 2;

  typedef enum logic [1:0] {
    MODE_PRI = 2'd0,
    MODE_SEC = 2'd1,
    MODE_RET = 2'd2,  // heading back to primary, still clocked from secondary
    MODE_INT = 2'd3
  } srcMode_t;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_IDLE  = 2'd1,
    PWR_SLEEP = 2'd2
  } pwrMode_t;

  // Control-to-datapath strobes: the state being entered on this edge
  typedef struct packed {
    srcMode_t modeNext;
    pwrMode_t pwrNext;
  } seqCmd_t;

  function automatic int srcIndex(input srcMode_t m);
    case (m)
      MODE_PRI: srcIndex = SRC_PRI;
      MODE_SEC: srcIndex = SRC_SEC;
      MODE_RET: srcIndex = SRC_SEC;
      default:  srcIndex = SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selField,
  input  logic             idleEn,
  input  logic             sleepReq,
  input  logic             wakePulse,
  input  logic             priReady,
  input  logic             secEnable,
  input  logic             secReady,
  output seqCmd_t          cmd
);
  srcMode_t modeQ, modeD;
  pwrMode_t pwrQ, pwrD;

  logic wantInt, wantSec, secOk, switchOk;

  assign wantInt  = selField[SEL_W-1];
  assign wantSec  = (selField == 2'b01);
  assign secOk    = secEnable && secReady;
  // Source changes only while running, or on the wake edge itself
  assign switchOk = (pwrQ == PWR_RUN) || wakePulse;

  always_comb begin
    modeD = modeQ;
    if (switchOk) begin
      unique case (modeQ)
        MODE_PRI: begin
          if (wantInt)              modeD = MODE_INT;
          else if (wantSec && secOk) modeD = MODE_SEC;
        end
        MODE_SEC: begin
          if (wantInt)       modeD = MODE_INT;
          else if (!wantSec) modeD = MODE_RET;
        end
        MODE_RET: begin
          if (wantInt)       modeD = MODE_INT;
          else if (wantSec)  modeD = MODE_SEC;
          else if (priReady) modeD = MODE_PRI;
        end
        MODE_INT: begin
          if (!wantInt) begin
            if (!wantSec)   modeD = MODE_PRI;
            else if (secOk) modeD = MODE_SEC;
          end
        end
      endcase
    end
  end

  always_comb begin
    pwrD = pwrQ;
    case (pwrQ)
      PWR_RUN:  if (sleepReq) pwrD = idleEn ? PWR_IDLE : PWR_SLEEP;
      default:  if (wakePulse) pwrD = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_PRI;
      pwrQ  <= PWR_RUN;
    end else begin
      modeQ <= modeD;
      pwrQ  <= pwrD;
    end
  end

  assign cmd.modeNext = modeD;
  assign cmd.pwrNext  = pwrD;
endmodule

// File: rtl/clkseq_dp.sv
module clkseq_dp
  import clkseq_pkg::*;
#(
  parameter int FREQ_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  input  logic               priReady,
  input  logic               secEnable,
  input  logic [FREQ_W-1:0]  intFreq,
  input  logic               intSrcSel,
  input  logic               intStable,
  output logic [NUM_SRC-1:0] srcSel,
  output logic               priOscEn,
  output logic               secOscEn,
  output logic               intOscEn,
  output logic               lowFreqActive,
  output logic               coreClkEn,
  output logic               periClkEn,
  output logic               secRunFlag,
  output logic               priStableFlag,
  output logic               intFastStable
);
  localparam logic [NUM_SRC-1:0] SRC_RESET = NUM_SRC'(1) << SRC_PRI;

  logic [NUM_SRC-1:0] srcSelD;
  logic intOscEnD;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_srcDecode
    assign srcSelD[i] = (srcIndex(cmd.modeNext) == i);
  end

  assign intOscEnD = (|intFreq) || intSrcSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel        <= SRC_RESET;
      priOscEn      <= 1'b1;
      secOscEn      <= 1'b0;
      intOscEn      <= 1'b0;
      lowFreqActive <= 1'b0;
      coreClkEn     <= 1'b1;
      periClkEn     <= 1'b1;
      secRunFlag    <= 1'b0;
      priStableFlag <= 1'b0;
      intFastStable <= 1'b0;
    end else begin
      srcSel        <= srcSelD;
      priOscEn      <= (cmd.modeNext == MODE_PRI) || (cmd.modeNext == MODE_RET);
      secOscEn      <= secEnable || srcSelD[SRC_SEC];
      intOscEn      <= intOscEnD;
      lowFreqActive <= srcSelD[SRC_INT] && !intOscEnD;
      coreClkEn     <= (cmd.pwrNext == PWR_RUN);
      periClkEn     <= (cmd.pwrNext != PWR_SLEEP);
      secRunFlag    <= srcSelD[SRC_SEC];
      priStableFlag <= (cmd.modeNext == MODE_PRI) && priReady;
      // stable only after the enable has been out for at least one cycle
      intFastStable <= intOscEnD && intOscEn && intStable;
    end
  end
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int FREQ_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        selField,
  input  logic              idleEn,
  input  logic              sleepReq,
  input  logic              wakePulse,
  input  logic              priReady,
  input  logic              secEnable,
  input  logic              secReady,
  input  logic [FREQ_W-1:0] intFreq,
  input  logic              intSrcSel,
  input  logic              intStable,
  output logic [2:0]        srcSel,
  output logic              priOscEn,
  output logic              secOscEn,
  output logic              intOscEn,
  output logic              lowFreqActive,
  output logic              coreClkEn,
  output logic              periClkEn,
  output logic              secRunFlag,
  output logic              priStableFlag,
  output logic              intFastStable
);
  seqCmd_t cmd;

  clkseq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .selField  (selField),
    .idleEn    (idleEn),
    .sleepReq  (sleepReq),
    .wakePulse (wakePulse),
    .priReady  (priReady),
    .secEnable (secEnable),
    .secReady  (secReady),
    .cmd       (cmd)
  );

  clkseq_dp #(.FREQ_W(FREQ_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .priReady      (priReady),
    .secEnable     (secEnable),
    .intFreq       (intFreq),
    .intSrcSel     (intSrcSel),
    .intStable     (intStable),
    .srcSel        (srcSel),
    .priOscEn      (priOscEn),
    .secOscEn      (secOscEn),
    .intOscEn      (intOscEn),
    .lowFreqActive (lowFreqActive),
    .coreClkEn     (coreClkEn),
    .periClkEn     (periClkEn),
    .secRunFlag    (secRunFlag),
    .priStableFlag (priStableFlag),
    .intFastStable (intFastStable)
  );
endmodule

// File: rtl/clkseq_checks.sv
module clkseq_checks #(
  parameter int FREQ_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        selField,
  input logic              sleepReq,
  input logic              wakePulse,
  input logic              priReady,
  input logic              secEnable,
  input logic              secReady,
  input logic              intStable,
  input logic [2:0]        srcSel,
  input logic              priOscEn,
  input logic              intOscEn,
  input logic              lowFreqActive,
  input logic              coreClkEn,
  input logic              periClkEn,
  input logic              secRunFlag,
  input logic              priStableFlag,
  input logic              intFastStable
);
  assert_src_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(srcSel) == 1);

  assert_sec_no_pri_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    secRunFlag |-> !priStableFlag);

  assert_sec_entry_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srcSel[1]) |-> $past(selField == 2'b01 && secEnable && secReady));

  assert_return_waits_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(srcSel[1]) && srcSel[0]) |-> $past(priReady));

  assert_int_pri_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    srcSel[2] |-> (!priOscEn && !priStableFlag));

  assert_low_freq_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    lowFreqActive |-> (srcSel[2] && !intOscEn && !intFastStable));

  assert_int_stable_after_en_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFastStable) |-> ($past(intOscEn) && $past(intStable)));

  assert_sleep_order_R10: assert property (@(posedge clk) disable iff (!rstN)
    !periClkEn |-> !coreClkEn);

  assert_core_stop_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(sleepReq));

  assert_core_start_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> $past(wakePulse));

  assert_frozen_in_sleep_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!coreClkEn && $past(!coreClkEn)) |-> $stable(srcSel));
endmodule

bind clkseq_top clkseq_checks #(.FREQ_W(FREQ_W)) u_clkseqChecks (.*);

// File: tb/test_clkseq_top.sv
module test_clkseq_top;
  localparam int FREQ_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] selField = 2'b00;
  logic idleEn = 1'b0, sleepReq = 1'b0, wakePulse = 1'b0;
  logic priReady = 1'b1, secEnable = 1'b0, secReady = 1'b0;
  logic [FREQ_W-1:0] intFreq = '0;
  logic intSrcSel = 1'b0, intStable = 1'b0;
  logic [2:0] srcSel;
  logic priOscEn, secOscEn, intOscEn, lowFreqActive;
  logic coreClkEn, periClkEn, secRunFlag, priStableFlag, intFastStable;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkseq_top #(.FREQ_W(FREQ_W)) i_clkseq_top (.*);

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R2: one-hot source select, every cycle
  always @(negedge clk) if (rstN && !done) chk("R2", "srcSel onehot", 8'($countones(srcSel)), 8'd1);

  task automatic testReset();
    step(2);
    rstN = 1'b1;
    chk("R1", "srcSel", 8'(srcSel), 8'h01);
    chk("R1", "priOscEn", 8'(priOscEn), 8'h1);
    chk("R1", "core/peri", 8'({coreClkEn, periClkEn}), 8'h3);
    chk("R1", "secRun/intStable", 8'({secRunFlag, intFastStable}), 8'h0);
    step(1);
    chk("R1", "priStable", 8'(priStableFlag), 8'h1);
  endtask

  task automatic testSecEntry();
    selField = 2'b01; secEnable = 1'b0; secReady = 1'b1;
    step(3);
    chk("R4", "no entry without enable", 8'(srcSel), 8'h01);
    secEnable = 1'b1; secReady = 1'b0;
    step(3);
    chk("R4", "no entry without ready", 8'({srcSel, secRunFlag}), 8'h02);
    secReady = 1'b1;
    step(1);
    chk("R3", "srcSel", 8'(srcSel), 8'h02);
    chk("R3", "priOscEn", 8'(priOscEn), 8'h0);
    chk("R3", "secRun/priStable", 8'({secRunFlag, priStableFlag}), 8'h2);
    chk("R3", "secOscEn", 8'(secOscEn), 8'h1);
  endtask

  task automatic testReturn();
    priReady = 1'b0; selField = 2'b00;
    step(1);
    chk("R5", "still on secondary", 8'(srcSel), 8'h02);
    chk("R5", "primary started", 8'(priOscEn), 8'h1);
    step(3);
    chk("R5", "waiting secRun/priStable", 8'({secRunFlag, priStableFlag}), 8'h2);
    priReady = 1'b1;
    step(1);
    chk("R5", "switched srcSel", 8'(srcSel), 8'h01);
    chk("R5", "secRun/priStable", 8'({secRunFlag, priStableFlag}), 8'h1);
    chk("R5", "secondary kept", 8'(secOscEn), 8'h1);
  endtask

  task automatic testInternal();
    intStable = 1'b1;
    selField = 2'b11;
    step(1);
    chk("R6", "srcSel sel=11", 8'(srcSel), 8'h04);
    chk("R6", "priOscEn/priStable", 8'({priOscEn, priStableFlag}), 8'h0);
    chk("R7", "intOscEn/intFastStable", 8'({intOscEn, intFastStable}), 8'h0);
    chk("R7", "lowFreqActive", 8'(lowFreqActive), 8'h1);
    selField = 2'b10;
    step(2);
    chk("R6", "lower bit ignored", 8'(srcSel), 8'h04);
  endtask

  task automatic testIntStartup();
    intStable = 1'b0; intFreq = 3'b101;
    step(1);
    chk("R8", "intOscEn", 8'(intOscEn), 8'h1);
    chk("R8", "lowFreq/flag", 8'({lowFreqActive, intFastStable}), 8'h0);
    step(3);
    chk("R8", "flag waits", 8'(intFastStable), 8'h0);
    chk("R8", "clocks continue", 8'({srcSel, coreClkEn}), 8'h09);
    intStable = 1'b1;
    step(1);
    chk("R8", "flag set", 8'(intFastStable), 8'h1);
  endtask

  task automatic testIntPreStable();
    selField = 2'b00;
    step(1);
    chk("R9", "back on primary", 8'(srcSel), 8'h01);
    chk("R9", "flag kept off-mode", 8'(intFastStable), 8'h1);
    selField = 2'b10;
    step(1);
    chk("R9", "internal srcSel", 8'(srcSel), 8'h04);
    chk("R9", "flag kept on entry", 8'(intFastStable), 8'h1);
    selField = 2'b00;
    step(1);
    chk("R9", "return primary", 8'(srcSel), 8'h01);
  endtask

  task automatic testSleepWake();
    idleEn = 1'b0; sleepReq = 1'b1;
    step(1);
    sleepReq = 1'b0;
    chk("R10", "sleep core/peri", 8'({coreClkEn, periClkEn}), 8'h0);
    selField = 2'b10;
    step(3);
    chk("R12", "select ignored asleep", 8'(srcSel), 8'h01);
    wakePulse = 1'b1;
    step(1);
    wakePulse = 1'b0;
    chk("R11", "wake core/peri", 8'({coreClkEn, periClkEn}), 8'h3);
    chk("R11", "follows select", 8'(srcSel), 8'h04);
    idleEn = 1'b1; sleepReq = 1'b1;
    step(1);
    sleepReq = 1'b0;
    chk("R10", "idle core/peri", 8'({coreClkEn, periClkEn}), 8'h1);
    selField = 2'b01; secEnable = 1'b1; secReady = 1'b1;
    step(2);
    chk("R12", "select ignored idle", 8'(srcSel), 8'h04);
    wakePulse = 1'b1;
    step(1);
    wakePulse = 1'b0;
    chk("R11", "idle wake core/peri", 8'({coreClkEn, periClkEn}), 8'h3);
    chk("R11", "wake to secondary", 8'(srcSel), 8'h02);
  endtask

  initial begin
    testReset();
    testSecEntry();
    testReturn();
    testInternal();
    testIntStartup();
    testIntPreStable();
    testSleepWake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end
endmodule